// File: doc/BRIEF.md
# Conflict-Allocating Instruction Cache

This block sits between an instruction sequencer and a program-memory port that is shared by instruction fetches and data accesses. In most cycles the fetch goes straight to memory and the word read back is passed through unchanged. When a data access claims the port in the same cycle (the conflict input is high), the fetch must be served from a small two-way set-associative store of 48-bit instruction words. If the word is present, it is delivered at once, so the data access and the fetch finish together.

If the conflicting fetch misses, the block holds the sequencer for one cycle. In the next cycle the sequencer keeps the same address and the port is free, so the word is read from memory, handed on, and written into the store. Only words that caused a collision are ever stored, so a loop that reads program-memory data keeps exactly the instructions it needs. A disable input turns the store off for lookups and fills. A freeze input keeps the current contents usable but blocks new fills. A flush input, like reset, empties the store.

Top module: `icache_selective`

## Requirements
- R1: When conflict is low and no fill is pending, the block drives instr equal to mem_rdata, instr_valid high and stall low in the same cycle, and it stores nothing. A later conflicting fetch of that address therefore misses.
- R2: When conflict is high, cache_off is low and the address is held in either way, instr is the stored word, instr_valid is high and stall is low in the same cycle. Memory data is ignored.
- R3: A conflicting fetch that is not served from the store raises stall, drops instr_valid and drives instr to zero for exactly one cycle. In the next cycle instr equals mem_rdata, instr_valid is high and stall is low, whatever the conflict input is.
- R4: The word delivered in the cycle after a miss is written into the store. A later conflicting fetch of that address returns that word, even if memory has changed since.
- R5: The set index is address bits [3:0] and the tag is bits [23:4]. Two addresses with the same index and different tags can be held at the same time, one in each way.
- R6: A fill uses an empty way if there is one, way 0 first. Otherwise it replaces the way of the set that was used less recently. Both hits and fills count as use.
- R7: While cache_off is high, every conflicting fetch stalls, including fetches of stored addresses, and a miss taken while disabled writes nothing. The contents stay intact for when cache_off goes low again.
- R8: While freeze is high, conflicting hits are still served. A miss taken while freeze is high stalls but writes nothing.
- R9: A flush pulse empties every way of every set, and replacement restarts as after reset. Flush takes priority over a fill or a use update in the same cycle.
- R10: During and after reset the store is empty and no fill is pending, so stall is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the store at the next edge |
| cache_off | input | 1 | Disables lookups and fills |
| freeze | input | 1 | Keeps contents, blocks new fills |
| fetch_addr | input | 24 | Instruction fetch address, held by the sequencer during a stall |
| conflict | input | 1 | A data access owns the memory port this cycle |
| mem_rdata | input | 48 | Word read from program memory at fetch_addr |
| instr | output | 48 | Instruction delivered to the sequencer |
| instr_valid | output | 1 | instr is valid this cycle |
| stall | output | 1 | Sequencer must hold its fetch address |

## Verification
The bench changes the memory contents between a fill and the following hit. A design that reads memory on a conflicting hit, instead of reading the store, returns the newer word and is caught. It aims a third tag at a full set after a chosen sequence of hits, so a replacement choice that ignores hits evicts the wrong address, and a later fetch of that address then misses. It checks that fetches made while disabled or frozen leave no entry behind, and that a disabled store still stalls on addresses it holds. A design that fills on every miss, or that keeps honouring the disable after it is released, gives a hit or a stall one cycle out of place.

// File: rtl/icache_pkg.sv
package icache_pkg;
   typedef enum logic [1:0] {
      SRC_MEMORY = 2'd0,
      SRC_STORE  = 2'd1,
      SRC_NONE   = 2'd2
   } instr_src_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
   parameter int SETS  = 16,
   parameter int WAYS  = 2,
   parameter int TAG_W = 20,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic [WAYS-1:0]  hit_way,
   input  logic [IDX_W-1:0] vq_idx,
   output logic [WAYS-1:0]  vq_valid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WAYS-1:0]  wr_way,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [SETS-1:0][WAYS-1:0] vld;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
      end else if (flush_i) begin
         vld <= '0;
      end else if (wr_en) begin
         vld[wr_idx] <= vld[wr_idx] | wr_way;
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tags [SETS];
      always_ff @(posedge clk) begin
         if (wr_en && wr_way[w]) begin
            tags[wr_idx] <= wr_tag;
         end
      end
      assign hit_way[w] = vld[lk_idx][w] && (tags[lk_idx] == lk_tag);
   end

   assign vq_valid = vld[vq_idx];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !flush_i |=> (vld[$past(wr_idx)] & $past(wr_way)) != '0); // R4
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> vld == '0); // R9
   AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_way)); // R5
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
   parameter int SETS   = 16,
   parameter int WAYS   = 2,
   parameter int DATA_W = 48,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WAYS-1:0]   rd_way,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WAYS-1:0]   wr_way,
   input  logic [DATA_W-1:0] wr_data
);
   logic [WAYS-1:0][DATA_W-1:0] way_word;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [DATA_W-1:0] words [SETS];
      always_ff @(posedge clk) begin
         if (wr_en && wr_way[w]) begin
            words[wr_idx] <= wr_data;
         end
      end
      assign way_word[w] = rd_way[w] ? words[rd_idx] : '0;
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < WAYS; w++) begin
         rd_data = rd_data | way_word[w];
      end
   end
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
   parameter int SETS = 16,
   parameter int WAYS = 2,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic [WAYS-1:0]  touch_way,
   input  logic [IDX_W-1:0] q_idx,
   input  logic [WAYS-1:0]  q_valid,
   output logic [WAYS-1:0]  victim
);
   if (WAYS != 2) begin : g_bad_ways
      $error("replacement supports exactly two ways");
   end

   logic [SETS-1:0] older_q;   // 1: way 1 is the older one

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         older_q <= '0;
      end else if (flush_i) begin
         older_q <= '0;
      end else if (touch_en) begin
         older_q[touch_idx] <= touch_way[0];
      end
   end

   always_comb begin
      if (!q_valid[0]) begin
         victim = 2'b01;
      end else if (!q_valid[1]) begin
         victim = 2'b10;
      end else begin
         victim = older_q[q_idx] ? 2'b10 : 2'b01;
      end
   end

   AST_VICTIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(victim) == 1); // R6
   AST_TOUCHED_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en && !flush_i && q_idx == touch_idx && q_valid == 2'b11
      |=> (q_valid != 2'b11) || (q_idx != $past(touch_idx)) || (victim != $past(touch_way))); // R6
endmodule

// File: rtl/icache_selective.sv
module icache_selective #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 48,
   parameter int WORDS  = 32,
   parameter int WAYS   = 2,
   localparam int SETS  = WORDS / WAYS,
   localparam int IDX_W = $clog2(SETS),
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              cache_off,
   input  logic              freeze,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              conflict,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] instr,
   output logic              instr_valid,
   output logic              stall
);
   import icache_pkg::*;

   if (WORDS % WAYS != 0 || TAG_W < 1) begin : g_bad_geom
      $error("WORDS must divide by WAYS and leave tag bits");
   end

   logic              pend_q;
   logic              alloc_q;
   logic [ADDR_W-1:0] pend_addr_q;

   logic [IDX_W-1:0]  lk_idx;
   logic [TAG_W-1:0]  lk_tag;
   logic [IDX_W-1:0]  fill_idx;
   logic [TAG_W-1:0]  fill_tag;
   logic [WAYS-1:0]   hit_way;
   logic [WAYS-1:0]   fill_valid;
   logic [WAYS-1:0]   victim;
   logic [DATA_W-1:0] store_word;
   logic              look_hit;
   logic              fill_en;
   logic              touch_en;
   logic [IDX_W-1:0]  touch_idx;
   logic [WAYS-1:0]   touch_way;
   instr_src_e        src;

   assign lk_idx   = fetch_addr[IDX_W-1:0];
   assign lk_tag   = fetch_addr[ADDR_W-1:IDX_W];
   assign fill_idx = pend_addr_q[IDX_W-1:0];
   assign fill_tag = pend_addr_q[ADDR_W-1:IDX_W];

   icache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .lk_idx(lk_idx), .lk_tag(lk_tag), .hit_way(hit_way),
      .vq_idx(fill_idx), .vq_valid(fill_valid),
      .wr_en(fill_en), .wr_idx(fill_idx), .wr_way(victim), .wr_tag(fill_tag)
   );

   icache_data_store #(.SETS(SETS), .WAYS(WAYS), .DATA_W(DATA_W)) u_data (
      .clk(clk),
      .rd_idx(lk_idx), .rd_way(hit_way), .rd_data(store_word),
      .wr_en(fill_en), .wr_idx(fill_idx), .wr_way(victim), .wr_data(mem_rdata)
   );

   icache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .touch_en(touch_en), .touch_idx(touch_idx), .touch_way(touch_way),
      .q_idx(fill_idx), .q_valid(fill_valid), .victim(victim)
   );

   assign look_hit = (|hit_way) && !cache_off;

   always_comb begin
      if (pend_q || !conflict) begin
         src = SRC_MEMORY;
      end else if (look_hit) begin
         src = SRC_STORE;
      end else begin
         src = SRC_NONE;
      end
   end

   always_comb begin
      unique case (src)
         SRC_MEMORY: instr = mem_rdata;
         SRC_STORE:  instr = store_word;
         default:    instr = '0;
      endcase
   end

   assign instr_valid = (src != SRC_NONE);
   assign stall       = (src == SRC_NONE);
   assign fill_en     = pend_q && alloc_q;
   assign touch_en    = fill_en || (src == SRC_STORE);
   assign touch_idx   = fill_en ? fill_idx : lk_idx;
   assign touch_way   = fill_en ? victim : hit_way;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         alloc_q     <= 1'b0;
         pend_addr_q <= '0;
      end else if (pend_q) begin
         pend_q      <= 1'b0;
         alloc_q     <= 1'b0;
      end else if (stall) begin
         pend_q      <= 1'b1;
         alloc_q     <= !cache_off && !freeze;
         pend_addr_q <= fetch_addr;
      end
   end

   AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall && instr_valid); // R3
   AST_NOCONF_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !conflict |-> !stall && instr == mem_rdata); // R1
   AST_OFF_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      cache_off && conflict && !pend_q |-> stall); // R7
   AST_HELD_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      stall && (freeze || cache_off) |=> !fill_en); // R8
endmodule

// File: tb/icache_selective_tb.sv
module icache_selective_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        cache_off = 1'b0;
   logic        freeze = 1'b0;
   logic [23:0] fetch_addr = '0;
   logic        conflict = 1'b0;
   logic [47:0] mem_rdata = '0;
   logic [47:0] instr;
   logic        instr_valid;
   logic        stall;

   icache_selective u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .cache_off(cache_off),
      .freeze(freeze), .fetch_addr(fetch_addr), .conflict(conflict),
      .mem_rdata(mem_rdata), .instr(instr), .instr_valid(instr_valid),
      .stall(stall)
   );

   always #10 clk = ~clk;

   int   n_vec = 0;
   int   n_bad = 0;
   logic [7:0]  ver = 8'h11;
   logic        d_off = 0, d_frz = 0, d_flush = 0;

   logic [19:0] mt [16][2];
   logic        mv [16][2];
   logic        ml [16];
   logic [47:0] md [16][2];
   logic        m_pend = 0, m_alloc = 0;
   logic [23:0] m_paddr = '0;

   function automatic logic [47:0] memword(logic [23:0] a);
      return {a ^ {ver, ver, ver}, ~a};
   endfunction

   task automatic model_clear();
      for (int s = 0; s < 16; s++) begin
         ml[s] = 0;
         for (int w = 0; w < 2; w++) mv[s][w] = 0;
      end
   endtask

   task automatic check(string t, string what, logic [47:0] act, logic [47:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
      end
   endtask

   task automatic step(logic [23:0] a, logic c, string tag);
      logic [23:0] ea;
      logic [3:0]  ix;
      int          hw;
      logic        ev, es;
      logic [47:0] ei;
      string       t;
      ea = m_pend ? m_paddr : a;
      @(negedge clk);
      fetch_addr = ea; conflict = c; mem_rdata = memword(ea);
      cache_off = d_off; freeze = d_frz; flush = d_flush;
      #2;
      ix = ea[3:0];
      hw = -1;
      for (int w = 0; w < 2; w++) if (mv[ix][w] && mt[ix][w] == ea[23:4]) hw = w;
      if (m_pend) begin ev = 1; es = 0; ei = memword(ea); t = "R3"; end
      else if (!c) begin ev = 1; es = 0; ei = memword(ea); t = "R1"; end
      else if (!d_off && hw >= 0) begin ev = 1; es = 0; ei = md[ix][hw]; t = "R2"; end
      else begin ev = 0; es = 1; ei = '0; t = d_off ? "R7" : (d_frz ? "R8" : "R3"); end
      if (tag != "") t = tag;
      check(t, "stall", 48'(stall), 48'(es));
      check(t, "valid", 48'(instr_valid), 48'(ev));
      check(t, "instr", instr, ei);
      if (d_flush) model_clear();
      else if (m_pend && m_alloc) begin
         int v;
         v = !mv[ix][0] ? 0 : (!mv[ix][1] ? 1 : int'(ml[ix]));
         mv[ix][v] = 1; mt[ix][v] = ea[23:4]; md[ix][v] = memword(ea);
         ml[ix] = (v == 0);
      end else if (!m_pend && c && !d_off && hw >= 0) ml[ix] = (hw == 0);
      if (m_pend) begin m_pend = 0; m_alloc = 0; end
      else if (es) begin m_pend = 1; m_alloc = !d_off && !d_frz; m_paddr = ea; end
   endtask

   task automatic cfetch(logic [23:0] a, string tag);
      step(a, 1'b1, tag);
      if (m_pend) step(a, 1'b0, "");
   endtask

   localparam logic [23:0] A = 24'h012345;
   localparam logic [23:0] B = 24'h0AB005;
   localparam logic [23:0] C = 24'h777775;
   localparam logic [23:0] E = 24'h00F0E9;
   localparam logic [23:0] F = 24'h0C0C0A;

   initial begin
      void'($urandom(32'd2024));
      model_clear();
      repeat (3) @(negedge clk);
      #2;
      check("R10", "stall in reset", 48'(stall), 48'd0);
      @(negedge clk); rst_n = 1'b1;
      step(A, 0, "R10");
      // R1: pass-through fetch does not allocate
      step(A, 0, "R1");
      cfetch(A, "R1");
      // R4: filled word survives a memory change
      ver = 8'h5C;
      cfetch(A, "R4");
      // R5: same index, second tag
      cfetch(B, "");
      cfetch(A, "R5");
      cfetch(B, "R5");
      // R6: A is older, so C replaces it
      cfetch(C, "");
      cfetch(B, "R6");
      cfetch(C, "R6");
      cfetch(A, "R6");
      // R7: disabled store stalls on held word and does not fill
      d_off = 1;
      cfetch(A, "R7");
      cfetch(E, "R7");
      d_off = 0;
      cfetch(A, "R7");
      cfetch(E, "R7");
      // R8: frozen store serves hits, refuses fills
      d_frz = 1;
      cfetch(E, "R8");
      cfetch(F, "R8");
      cfetch(F, "R8");
      d_frz = 0;
      // R9: flush empties the store
      d_flush = 1; step(A, 0, "R9"); d_flush = 0;
      cfetch(E, "R9");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [23:0] ra;
         ra = {20'(($urandom % 3) * 20'h1F3A7), 4'($urandom % 16)};
         d_off = ($urandom % 16) == 0;
         d_frz = ($urandom % 8) == 0;
         d_flush = ($urandom % 128) == 0;
         if ($urandom % 64 == 0) ver = 8'($urandom);
         step(ra, 1'($urandom % 2), "");
      end
      d_off = 0; d_frz = 0; d_flush = 0;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule